// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address with a segmented page table. Each virtual address carries a region selector in its top two bits, a 21-bit virtual page number and a 9-bit byte offset, so pages are 512 bytes. A system-space address needs a single lookup in the system page table. The system page table base is a physical address. A user-region address needs two lookups. The user page table base is a virtual address in system space, so the address of the user page table entry must first be translated through the system page table before that entry can be fetched.

A client presents a virtual address on a ready/valid request port. The walker reads page table entries one at a time over a read port with a ready/valid request channel and a ready/valid response channel. When the walk ends it pulses a one-cycle result carrying either the physical address or a fault flag. Two write strobes load the user and system base registers.

The controller has five states. IDLE accepts a request. SYS_PTE_READ fetches the system page table entry. USR_PTE_READ fetches the user page table entry. DONE presents a translated address for one cycle. FAULT presents a fault for one cycle. The transitions are:

- IDLE to SYS_PTE_READ when a system address, or a user address whose entry address lies in system space, is accepted.
- IDLE to FAULT when the selector or the entry address is unusable.
- SYS_PTE_READ to DONE for a system address with a valid entry.
- SYS_PTE_READ to USR_PTE_READ for a user address with a valid entry.
- SYS_PTE_READ to FAULT and USR_PTE_READ to FAULT on an invalid entry.
- USR_PTE_READ to DONE on a valid entry.
- DONE to IDLE and FAULT to IDLE unconditionally.

Inside each read state, the request is issued first and the response is awaited afterwards.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `mem_req_valid` is 0 and `res_valid` is 0.
- R2: The virtual address fields are laid out as follows: bits 31:30 are the selector, bits 29:9 are the page number and bits 8:0 are the offset. A page table entry is 32 bits wide, with bit 31 as the valid bit and bits 20:0 as the frame number. Bits 30:21 of an entry are ignored. A translated address is {2'b00, frame, offset}.
- R3: For selector 2'b10, exactly one read is issued, at address sys_base + page*4. If that entry is valid, the result is the translated address built from its frame.
- R4: For selector 2'b00, the entry virtual address is ev = usr_base + page*4. The first read goes to sys_base + ev[29:9]*4. The second read goes to {2'b00, frame of the first entry, ev[8:0]}. The result uses the frame of the second entry.
- R5: Selector 2'b01 or 2'b11 ends the walk in a fault with no memory read.
- R6: An entry with bit 31 clear, at either level, ends the walk in a fault with no further read.
- R7: For a user address whose ev[31:30] is not 2'b10, the walk faults with no memory read.
- R8: At most one read is outstanding at a time. A request held without `mem_req_ready` keeps its valid and address unchanged.
- R9: `res_valid` is a one-cycle pulse followed by a return to idle. `res_fault` is only set with `res_valid`, and on a fault `res_paddr` is 0.
- R10: Writing a base register changes the addresses used by every walk accepted after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_usr | input | 1 | Load the user base register from `base_wdata` |
| base_wr_sys | input | 1 | Load the system base register from `base_wdata` |
| base_wdata | input | 32 | Base register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Physical address of the entry read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker awaits read data |
| mem_rsp_data | input | 32 | Page table entry read back |
| res_valid | output | 1 | Walk result pulse |
| res_fault | output | 1 | Walk ended in a fault |
| res_paddr | output | 32 | Translated physical address, 0 on fault |

## Verification
On every cycle, the assertions check the following:

- the single-outstanding read discipline;
- that a stalled read request is held unchanged;
- the one-cycle result pulse and the return to idle;
- that a fault result carries a zero address;
- that bad selectors fault at once;
- that a translated address keeps the request's offset.

Only the bench scenarios can show the rest. These are the exact addresses of the nested system and user entry reads, the order of those reads, and frame masking. They also cover faults at each level and the missing later reads that a fault implies. The last of them is that a reloaded base register steers the next walk.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
    localparam int VA_W      = 32;
    localparam int SEL_W     = 2;
    localparam int VPN_W     = 21;
    localparam int OFF_W     = 9;
    localparam int PFN_W     = 21;
    localparam int PTE_SHIFT = 2;
    localparam int VALID_BIT = 31;

    localparam logic [SEL_W-1:0] SEL_USER = 2'b00;
    localparam logic [SEL_W-1:0] SEL_SYS  = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYS_RD,
        ST_USR_RD,
        ST_DONE,
        ST_FAULT
    } walk_state_e;
endpackage

// File: rtl/ptw_base_regs.sv
`timescale 1ns/1ps
module ptw_base_regs #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_usr,
    input  logic         wr_sys,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] usr_base,
    output logic [W-1:0] sys_base
);
    localparam int NREG = 2;

    logic [NREG-1:0] wr_en;
    logic [W-1:0]    regs [NREG];

    assign wr_en = {wr_sys, wr_usr};

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wr_en[i])
                regs[i] <= wdata;
        end
    end

    assign usr_base = regs[0];
    assign sys_base = regs[1];
endmodule

// File: rtl/ptw_addr_calc.sv
`timescale 1ns/1ps
module ptw_addr_calc
    import ptw_pkg::*;
(
    input  logic [VA_W-1:0]  vaddr,
    input  logic [VA_W-1:0]  usr_base,
    input  logic [VA_W-1:0]  sys_base,
    input  logic [PFN_W-1:0] pte_pfn,
    output logic [SEL_W-1:0] sel,
    output logic [VA_W-1:0]  sys_pte_direct,
    output logic [VA_W-1:0]  sys_pte_nested,
    output logic             usr_pte_in_sys,
    output logic [VA_W-1:0]  usr_pte_pa,
    output logic [VA_W-1:0]  final_pa
);
    localparam int PAD_W = VA_W - PFN_W - OFF_W;

    function automatic logic [VA_W-1:0] scale(input logic [VPN_W-1:0] n);
        return VA_W'({n, {PTE_SHIFT{1'b0}}});
    endfunction

    logic [VPN_W-1:0] vpn;
    logic [OFF_W-1:0] off;
    logic [VA_W-1:0]  usr_pte_va;

    assign sel        = vaddr[VA_W-1 -: SEL_W];
    assign vpn        = vaddr[OFF_W +: VPN_W];
    assign off        = vaddr[OFF_W-1:0];
    assign usr_pte_va = usr_base + scale(vpn);

    assign usr_pte_in_sys = (usr_pte_va[VA_W-1 -: SEL_W] == SEL_SYS);
    assign sys_pte_direct = sys_base + scale(vpn);
    assign sys_pte_nested = sys_base + scale(usr_pte_va[OFF_W +: VPN_W]);
    assign usr_pte_pa     = {{PAD_W{1'b0}}, pte_pfn, usr_pte_va[OFF_W-1:0]};
    assign final_pa       = {{PAD_W{1'b0}}, pte_pfn, off};
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        base_wr_usr,
    input  logic        base_wr_sys,
    input  logic [31:0] base_wdata,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    output logic        mem_rsp_ready,
    input  logic [31:0] mem_rsp_data,
    output logic        res_valid,
    output logic        res_fault,
    output logic [31:0] res_paddr
);
    walk_state_e     state_q, state_d;
    logic [VA_W-1:0] va_q, va_d;
    logic [VA_W-1:0] addr_q, addr_d;
    logic [VA_W-1:0] pa_q, pa_d;
    logic            issued_q, issued_d;

    logic [VA_W-1:0]  usr_base, sys_base, calc_va;
    logic [SEL_W-1:0] sel;
    logic [VA_W-1:0]  sys_pte_direct, sys_pte_nested, usr_pte_pa, final_pa;
    logic             usr_pte_in_sys;
    logic             pte_valid;
    logic             reading;
    logic             unused_pte_bits;

    assign pte_valid       = mem_rsp_data[VALID_BIT];
    assign unused_pte_bits = ^mem_rsp_data[VALID_BIT-1:PFN_W];
    assign calc_va         = (state_q == ST_IDLE) ? req_vaddr : va_q;

    ptw_base_regs #(.W(VA_W)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_usr   (base_wr_usr),
        .wr_sys   (base_wr_sys),
        .wdata    (base_wdata),
        .usr_base (usr_base),
        .sys_base (sys_base)
    );

    ptw_addr_calc u_calc (
        .vaddr          (calc_va),
        .usr_base       (usr_base),
        .sys_base       (sys_base),
        .pte_pfn        (mem_rsp_data[PFN_W-1:0]),
        .sel            (sel),
        .sys_pte_direct (sys_pte_direct),
        .sys_pte_nested (sys_pte_nested),
        .usr_pte_in_sys (usr_pte_in_sys),
        .usr_pte_pa     (usr_pte_pa),
        .final_pa       (final_pa)
    );

    // Next-state and walk data
    always_comb begin
        state_d  = state_q;
        va_d     = va_q;
        addr_d   = addr_q;
        pa_d     = pa_q;
        issued_d = issued_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    va_d     = req_vaddr;
                    issued_d = 1'b0;
                    pa_d     = '0;
                    if (sel == SEL_SYS) begin
                        addr_d  = sys_pte_direct;
                        state_d = ST_SYS_RD;
                    end else if (sel == SEL_USER && usr_pte_in_sys) begin
                        addr_d  = sys_pte_nested;
                        state_d = ST_SYS_RD;
                    end else begin
                        state_d = ST_FAULT;
                    end
                end
            end
            ST_SYS_RD: begin
                if (!issued_q) begin
                    if (mem_req_ready) issued_d = 1'b1;
                end else if (mem_rsp_valid) begin
                    issued_d = 1'b0;
                    if (!pte_valid) begin
                        state_d = ST_FAULT;
                    end else if (sel == SEL_SYS) begin
                        pa_d    = final_pa;
                        state_d = ST_DONE;
                    end else begin
                        addr_d  = usr_pte_pa;
                        state_d = ST_USR_RD;
                    end
                end
            end
            ST_USR_RD: begin
                if (!issued_q) begin
                    if (mem_req_ready) issued_d = 1'b1;
                end else if (mem_rsp_valid) begin
                    issued_d = 1'b0;
                    if (!pte_valid) begin
                        state_d = ST_FAULT;
                    end else begin
                        pa_d    = final_pa;
                        state_d = ST_DONE;
                    end
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            va_q     <= '0;
            addr_q   <= '0;
            pa_q     <= '0;
            issued_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            va_q     <= va_d;
            addr_q   <= addr_d;
            pa_q     <= pa_d;
            issued_q <= issued_d;
        end
    end

    // Outputs
    always_comb begin
        reading       = (state_q == ST_SYS_RD) || (state_q == ST_USR_RD);
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = reading && !issued_q;
        mem_req_addr  = addr_q;
        mem_rsp_ready = reading && issued_q;
        res_valid     = (state_q == ST_DONE) || (state_q == ST_FAULT);
        res_fault     = (state_q == ST_FAULT);
        res_paddr     = (state_q == ST_DONE) ? pa_q : '0;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
`timescale 1ns/1ps
module ptw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        mem_rsp_valid,
    input logic        mem_rsp_ready,
    input logic        res_valid,
    input logic        res_fault,
    input logic [31:0] res_paddr
);
    logic [1:0] outstanding;
    logic [8:0] off_cap;
    logic       unused_va_bits;

    assign unused_va_bits = ^{req_vaddr[31], req_vaddr[29:9]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= '0;
            off_cap     <= '0;
        end else begin
            outstanding <= outstanding + 2'(mem_req_valid && mem_req_ready)
                                       - 2'(mem_rsp_valid && mem_rsp_ready);
            if (req_valid && req_ready) off_cap <= req_vaddr[8:0];
        end
    end

    a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> outstanding == 2'd0);
    a_r8_rsp_after_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_ready |-> outstanding == 2'd1);
    a_r8_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    a_r9_result_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid && req_ready);
    a_r9_fault_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> res_valid);
    a_r9_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_fault |-> res_paddr == 32'h0);
    a_r5_bad_selector: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_vaddr[30] |=> res_valid && res_fault);
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_fault |-> res_paddr[8:0] == off_cap && res_paddr[31:30] == 2'b00);
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .res_valid     (res_valid),
    .res_fault     (res_fault),
    .res_paddr     (res_paddr)
);

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        base_wr_usr, base_wr_sys;
    logic [31:0] base_wdata;
    logic        req_valid, req_ready;
    logic [31:0] req_vaddr;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid, mem_rsp_ready;
    logic [31:0] mem_rsp_data;
    logic        res_valid, res_fault;
    logic [31:0] res_paddr;

    always #2.5 clk = ~clk;

    ptw_walker u_ptw_walker (.*);

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [31:0] mem_img [logic [31:0]];
    logic [31:0] tb_usr, tb_sys;
    logic [31:0] exp_addr_q[$];
    string       addr_tag_q[$];
    logic [32:0] exp_res_q[$];
    string       res_tag_q[$];

    int          cyc = 0;
    bit          pend = 0, rsp_taken = 0;
    logic [31:0] pend_addr;
    int          delay = 0;
    logic [31:0] e_addr;
    logic [32:0] e_res;
    string       e_tag;

    task automatic check(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return mem_img.exists(a) ? mem_img[a] : 32'h0;
    endfunction

    function automatic logic [31:0] x4(input logic [20:0] n);
        return {9'b0, n, 2'b00};
    endfunction

    // Monitor: compares reads and results against the scoreboard queues
    always @(posedge clk) begin
        if (rst_n) begin
            cyc++;
            if (mem_req_valid && mem_req_ready) begin
                check(!pend && !mem_rsp_valid, "R8 read while another outstanding", 33'(pend), 33'h0);
                if (exp_addr_q.size() == 0) begin
                    check(1'b0, "R6 unexpected read", 33'(mem_req_addr), 33'h0);
                end else begin
                    e_addr = exp_addr_q.pop_front();
                    e_tag  = addr_tag_q.pop_front();
                    check(mem_req_addr == e_addr, e_tag, 33'(mem_req_addr), 33'(e_addr));
                end
                pend      = 1;
                pend_addr = mem_req_addr;
                delay     = cyc % 3;
            end
            if (mem_rsp_valid && mem_rsp_ready) rsp_taken = 1;
            if (res_valid) begin
                if (exp_res_q.size() == 0) begin
                    check(1'b0, "R9 unexpected result", {res_fault, res_paddr}, 33'h0);
                end else begin
                    e_res = exp_res_q.pop_front();
                    e_tag = res_tag_q.pop_front();
                    check({res_fault, res_paddr} == e_res, e_tag, {res_fault, res_paddr}, e_res);
                end
            end
        end
    end

    // Memory model driver
    initial begin
        mem_req_ready = 0;
        mem_rsp_valid = 0;
        mem_rsp_data  = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mem_req_ready = 0;
                mem_rsp_valid = 0;
                pend = 0;
                rsp_taken = 0;
            end else begin
                mem_req_ready = (cyc % 4) != 2;
                if (rsp_taken) begin
                    mem_rsp_valid = 0;
                    rsp_taken = 0;
                end
                if (pend && !mem_rsp_valid) begin
                    if (delay == 0) begin
                        mem_rsp_valid = 1;
                        mem_rsp_data  = mem_rd(pend_addr);
                        pend = 0;
                    end else begin
                        delay--;
                    end
                end
            end
        end
    end

    task automatic load_base(input bit usr, input logic [31:0] v);
        @(negedge clk);
        base_wdata  = v;
        base_wr_usr = usr;
        base_wr_sys = !usr;
        @(negedge clk);
        base_wr_usr = 0;
        base_wr_sys = 0;
        if (usr) tb_usr = v; else tb_sys = v;
    endtask

    task automatic map_sys(input logic [31:0] va, input logic [31:0] pte);
        mem_img[tb_sys + x4(va[29:9])] = pte;
    endtask

    task automatic map_user(input logic [31:0] va, input logic [31:0] pte_sys, input logic [31:0] pte_usr);
        logic [31:0] pv;
        pv = tb_usr + x4(va[29:9]);
        mem_img[tb_sys + x4(pv[29:9])] = pte_sys;
        mem_img[{2'b00, pte_sys[20:0], pv[8:0]}] = pte_usr;
    endtask

    // Driver: reference walk pushes expected reads and result, then issues the request
    task automatic walk(input logic [31:0] va, input string tag);
        logic [31:0] pv, a, p, q, pa;
        bit fault;
        fault = 1;
        pa = 0;
        if (va[31:30] == 2'b10) begin
            a = tb_sys + x4(va[29:9]);
            exp_addr_q.push_back(a);
            addr_tag_q.push_back("R3 system entry address");
            p = mem_rd(a);
            if (p[31]) begin
                fault = 0;
                pa = {2'b00, p[20:0], va[8:0]};
            end
        end else if (va[31:30] == 2'b00) begin
            pv = tb_usr + x4(va[29:9]);
            if (pv[31:30] == 2'b10) begin
                a = tb_sys + x4(pv[29:9]);
                exp_addr_q.push_back(a);
                addr_tag_q.push_back("R4 nested system entry address");
                p = mem_rd(a);
                if (p[31]) begin
                    a = {2'b00, p[20:0], pv[8:0]};
                    exp_addr_q.push_back(a);
                    addr_tag_q.push_back("R4 user entry address");
                    q = mem_rd(a);
                    if (q[31]) begin
                        fault = 0;
                        pa = {2'b00, q[20:0], va[8:0]};
                    end
                end
            end
        end
        exp_res_q.push_back({fault, pa});
        res_tag_q.push_back(tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 0;
        while (exp_res_q.size() != 0) @(negedge clk);
        check(exp_addr_q.size() == 0, "R6 missing read", 33'(exp_addr_q.size()), 33'h0);
        check(!res_valid && req_ready, "R9 pulse then idle", {31'b0, res_valid, req_ready}, 33'h1);
        exp_addr_q.delete();
        addr_tag_q.delete();
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 33'h0, 33'h1);
        finish_up();
    end

    initial begin
        rst_n = 0;
        req_valid = 0;
        req_vaddr = 0;
        base_wr_usr = 0;
        base_wr_sys = 0;
        base_wdata = 0;
        tb_usr = 0;
        tb_sys = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(req_ready && !mem_req_valid && !res_valid, "R1 reset idle",
              {30'b0, req_ready, mem_req_valid, res_valid}, 33'h4);

        load_base(1'b1, 32'h8AC4_0000);
        load_base(1'b0, 32'h000C_8000);

        // R4 with high entry bits set to check masking (R2)
        map_user(32'h3456_789A, 32'h8060_0123, 32'h8001_5A5A);
        walk(32'h3456_789A, "R4 R2 user translation");
        map_user(32'h0000_0200, 32'h8000_0456, 32'h8000_0777);
        walk(32'h0000_0200, "R4 user translation second page");
        // R3
        map_sys(32'h8000_1234, 32'h800A_BCDE);
        walk(32'h8000_1234, "R3 system translation");
        map_sys(32'hBFFF_FFFF, 32'h801F_FFFF);
        walk(32'hBFFF_FFFF, "R3 R2 top page top offset");
        // R6
        map_sys(32'h8000_4400, 32'h000A_BC00);
        walk(32'h8000_4400, "R6 invalid system entry");
        map_user(32'h1234_5600, 32'h0000_0999, 32'h8000_0001);
        walk(32'h1234_5600, "R6 invalid nested system entry");
        map_user(32'h0100_0010, 32'h8000_0AAA, 32'h7FFF_FFFF);
        walk(32'h0100_0010, "R6 invalid user entry");
        // R5
        walk(32'h4000_0000, "R5 selector 01 fault");
        walk(32'hC000_0FFF, "R5 selector 11 fault");
        // R7
        load_base(1'b1, 32'h4000_0000);
        walk(32'h3456_789A, "R7 user entry outside system space");
        // R10
        load_base(1'b1, 32'h8AC4_0000);
        load_base(1'b0, 32'h0020_0000);
        map_user(32'h0000_0200, 32'h8000_0321, 32'h8000_0654);
        walk(32'h0000_0200, "R10 user walk after base reload");
        map_sys(32'h8000_1234, 32'h8000_0042);
        walk(32'h8000_1234, "R10 system walk after base reload");

        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule